// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a target on a two-wire serial bus that gives a host byte-wide access to a sparse file of control and status registers. It samples SCL and SDA with a fast system clock through synchronizers and finds START and STOP conditions from SDA edges while SCL is high. It drives SDA only through an open-drain pull-down enable.

A write transfer carries the device address byte, a register pointer and one data byte. A read transfer first writes the pointer, then turns the bus round with a repeated START, or with a STOP followed by a START, and returns the addressed register. Read/write registers are exported to the rest of the chip as one flat vector. Read-only registers take their values from status inputs. Every byte that is returned raises a one-cycle read strobe, so that the chip can clear flags that clear on read. There is no address auto-increment.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges only the address bytes C0h (write) and C1h (read). Any other address byte gets no ACK, and the target then leaves SDA alone until the next START.
- R2: START, C0h, pointer, data byte, STOP stores the data byte in the addressed read/write register. The read/write registers are at 0Bh, 0Dh, 0Eh, 0Fh, 19h, 1Ah, 1Bh, 1Dh, 1Eh and 1Fh. They appear on `rw_regs` as slots 0 to 9 in that order, with slot k at bits [8k+7:8k]. The stored value appears once the data byte is complete.
- R3: Data bytes after the first in one write transfer are acknowledged but discarded.
- R4: START, C0h, pointer, then a repeated START (or a STOP and a START), then C1h returns the addressed register MSB first. SDA changes only while SCL is low, so the bit can be sampled while SCL is high.
- R5: Addresses 02h, 10h and 11h are read-only. They return `status_in` bits [7:0], [15:8] and [23:16] respectively. Writes to them are acknowledged and change no register.
- R6: Address 00h always reads 15h. Writes to it are acknowledged and change no register.
- R7: Unmapped addresses read as 00h. Writes to them are acknowledged and change no register.
- R8: Reset clears every read/write register to 00h, which leaves bit 0 of register 0Fh (radio power) at 0 (standby). Reset also releases SDA.
- R9: After the last bit of each returned byte, `rd_stb` pulses for one cycle with the register address on `rd_stb_addr`. If the host ACKs a returned byte, the same register is sent again. Write transfers never pulse `rd_stb`.
- R10: The target changes its SDA drive only while SCL is low.
- R11: A START or a STOP anywhere in a transfer abandons it. A write cut off before its data byte changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| status_in | input | 24 | Read-only register values for 02h, 10h, 11h (low byte first) |
| rw_regs | output | 80 | Read/write register image, slot order as in R2 |
| rd_stb | output | 1 | One-cycle pulse per returned byte |
| rd_stb_addr | output | 8 | Register address of the returned byte |

## Verification
The bench goes after the edges of the transfer. If extra data bytes in a write were not discarded, the last byte rather than the first would end up in the register. If a foreign device address were not rejected, a later pointer byte would be acknowledged and a register would change. If a write cut short by STOP were stored, the target register would show a stale or partial value. The bench also reads back through both a repeated START and a STOP/START pair, and reads the ID, read-only and unmapped addresses. A wrong read multiplexer or a write leak into protected addresses shows up as a wrong byte on SDA or a change in the exported image. Counting strobes across single and double reads catches a strobe that fires on writes, fires twice, or is missing after an ACKed byte.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_RW = 10;
    localparam int NUM_RO = 3;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [6:0]        DEV_ADDR = 7'h60;
    localparam logic [BYTE_W-1:0] ID_ADDR  = 8'h00;
    localparam logic [BYTE_W-1:0] ID_VALUE = 8'h15;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_PTR,
        PH_WDAT,
        PH_RDAT,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic  en;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    // Address of each writable slot, in export order.
    function automatic byte_t rw_slot_addr(input int idx);
        case (idx)
            0:       return 8'h0B;
            1:       return 8'h0D;
            2:       return 8'h0E;
            3:       return 8'h0F;
            4:       return 8'h19;
            5:       return 8'h1A;
            6:       return 8'h1B;
            7:       return 8'h1D;
            8:       return 8'h1E;
            9:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Address of each status slot, in status_in order.
    function automatic byte_t ro_slot_addr(input int idx);
        case (idx)
            0:       return 8'h02;
            1:       return 8'h10;
            2:       return 8'h11;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Idle bus is high on both lines, so the pipes reset to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sda_s,
    input  logic    scl_rise,
    input  logic    scl_fall,
    input  logic    start_det,
    input  logic    stop_det,
    input  byte_t   rd_data,
    output byte_t   ptr,
    output wr_req_t wr,
    output logic    sda_oe,
    output logic    rd_stb,
    output byte_t   rd_stb_addr
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam byte_t            ADR_WR   = {DEV_ADDR, 1'b0};
    localparam byte_t            ADR_RD   = {DEV_ADDR, 1'b1};

    phase_e           phase;
    phase_e           nxt;
    logic [CNT_W-1:0] cnt;
    byte_t            shreg;
    logic             in_ack;
    logic             ack_go;
    logic             first_wr;
    logic             mst_ack;
    byte_t            rx_byte;

    assign rx_byte = {shreg[BYTE_W-2:0], sda_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            nxt         <= PH_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            in_ack      <= 1'b0;
            ack_go      <= 1'b0;
            first_wr    <= 1'b0;
            mst_ack     <= 1'b0;
            ptr         <= '0;
            wr          <= '0;
            sda_oe      <= 1'b0;
            rd_stb      <= 1'b0;
            rd_stb_addr <= '0;
        end else begin
            wr.en  <= 1'b0;
            rd_stb <= 1'b0;
            if (start_det) begin
                phase  <= PH_DEV;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (phase == PH_RDAT) begin
                if (scl_rise) begin
                    if (in_ack) mst_ack <= ~sda_s;
                    else        cnt     <= cnt + CNT_ONE;
                end else if (scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        if (mst_ack) begin
                            sda_oe <= ~rd_data[BYTE_W-1];
                            shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end else if (cnt == CNT_FULL) begin
                        sda_oe      <= 1'b0;
                        in_ack      <= 1'b1;
                        rd_stb      <= 1'b1;
                        rd_stb_addr <= ptr;
                    end else if (cnt != '0) begin
                        sda_oe <= ~shreg[BYTE_W-1];
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                    end
                end
            end else if (phase == PH_DEV || phase == PH_PTR || phase == PH_WDAT) begin
                if (scl_rise && !in_ack) begin
                    shreg <= rx_byte;
                    cnt   <= cnt + CNT_ONE;
                    if (cnt == CNT_LAST) begin
                        case (phase)
                            PH_DEV: begin
                                if (rx_byte == ADR_WR) begin
                                    ack_go <= 1'b1;
                                    nxt    <= PH_PTR;
                                end else if (rx_byte == ADR_RD) begin
                                    ack_go <= 1'b1;
                                    nxt    <= PH_RDAT;
                                end else begin
                                    ack_go <= 1'b0;
                                    nxt    <= PH_SKIP;
                                end
                            end
                            PH_PTR: begin
                                ptr      <= rx_byte;
                                ack_go   <= 1'b1;
                                nxt      <= PH_WDAT;
                                first_wr <= 1'b1;
                            end
                            default: begin
                                ack_go   <= 1'b1;
                                nxt      <= PH_WDAT;
                                first_wr <= 1'b0;
                                if (first_wr) begin
                                    wr.en   <= 1'b1;
                                    wr.addr <= ptr;
                                    wr.data <= rx_byte;
                                end
                            end
                        endcase
                    end
                end else if (scl_fall) begin
                    if (!in_ack && cnt == CNT_FULL) begin
                        in_ack <= 1'b1;
                        sda_oe <= ack_go;
                    end else if (in_ack) begin
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        phase  <= nxt;
                        if (nxt == PH_RDAT) begin
                            sda_oe <= ~rd_data[BYTE_W-1];
                            shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank
    import i2c_rf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  byte_t                    rd_addr,
    input  logic [NUM_RO*BYTE_W-1:0] status_in,
    output byte_t                    rd_data,
    output logic [NUM_RW*BYTE_W-1:0] rw_regs
);
    logic [NUM_RW-1:0] rw_hit;
    logic [NUM_RO-1:0] ro_hit;

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        localparam byte_t SLOT_ADDR = rw_slot_addr(g);
        byte_t q;
        always_ff @(posedge clk) begin
            if (rst)                                q <= '0;
            else if (wr.en && wr.addr == SLOT_ADDR) q <= wr.data;
        end
        assign rw_regs[g*BYTE_W +: BYTE_W] = q;
        assign rw_hit[g] = (rd_addr == SLOT_ADDR);
    end

    for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
        localparam byte_t SLOT_ADDR = ro_slot_addr(g);
        assign ro_hit[g] = (rd_addr == SLOT_ADDR);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ID_ADDR) rd_data = ID_VALUE;
        for (int i = 0; i < NUM_RW; i++)
            if (rw_hit[i]) rd_data = rw_regs[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < NUM_RO; i++)
            if (ro_hit[i]) rd_data = status_in[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic [NUM_RO*BYTE_W-1:0] status_in,
    output logic [NUM_RW*BYTE_W-1:0] rw_regs,
    output logic                     rd_stb,
    output logic [BYTE_W-1:0]        rd_stb_addr
);
    logic    sda_s;
    logic    scl_rise;
    logic    scl_fall;
    logic    start_det;
    logic    stop_det;
    byte_t   ptr;
    byte_t   rd_data;
    wr_req_t wr;

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rf_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .rd_data     (rd_data),
        .ptr         (ptr),
        .wr          (wr),
        .sda_oe      (sda_oe),
        .rd_stb      (rd_stb),
        .rd_stb_addr (rd_stb_addr)
    );

    i2c_rf_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_addr   (ptr),
        .status_in (status_in),
        .rd_data   (rd_data),
        .rw_regs   (rw_regs)
    );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk
    import i2c_rf_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     scl_i,
    input logic                     sda_oe,
    input logic [NUM_RW*BYTE_W-1:0] rw_regs,
    input logic                     rd_stb
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);                                  // R10

    AST_REGS_MOVE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        !$stable(rw_regs) |-> scl_i);                                  // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);                                           // R9

    AST_STROBE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> !sda_oe);                                           // R9

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rw_regs == '0 && !sda_oe));                    // R8
endmodule

bind i2c_regfile_target i2c_regfile_target_chk u_chk (.*);

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;
    localparam logic [7:0] ST02 = 8'h9D;
    localparam logic [7:0] ST10 = 8'hB2;
    localparam logic [7:0] ST11 = 8'h4C;
    localparam int NVEC = 16;
    // {register, value written, value expected on read}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h0B, 8'hA5, 8'hA5}, {8'h0D, 8'h3C, 8'h3C}, {8'h0E, 8'h81, 8'h81},
        {8'h0F, 8'h01, 8'h01}, {8'h19, 8'h7E, 8'h7E}, {8'h1A, 8'hFF, 8'hFF},
        {8'h1B, 8'h10, 8'h10}, {8'h1D, 8'hC3, 8'hC3}, {8'h1E, 8'h5A, 8'h5A},
        {8'h1F, 8'h96, 8'h96}, {8'h00, 8'h77, 8'h15}, {8'h02, 8'hFF, ST02},
        {8'h10, 8'hAA, ST10},  {8'h11, 8'h55, ST11},  {8'h05, 8'hEE, 8'h00},
        {8'h20, 8'h12, 8'h00}
    };
    localparam logic [7:0] RW_ADDR [10] = '{8'h0B, 8'h0D, 8'h0E, 8'h0F, 8'h19,
                                           8'h1A, 8'h1B, 8'h1D, 8'h1E, 8'h1F};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic [79:0] rw_regs;
    logic        rd_stb;
    logic [7:0]  rd_stb_addr;
    logic [7:0]  model [10];
    int          n_chk = 0;
    int          n_err = 0;
    int          stb_cnt = 0;
    logic [7:0]  stb_last = '0;

    always #2.5 clk = ~clk;
    assign sda_bus = ~(m_low | sda_oe);

    i2c_regfile_target u_i2c_regfile_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .status_in({ST11, ST10, ST02}), .rw_regs(rw_regs),
        .rd_stb(rd_stb), .rd_stb_addr(rd_stb_addr)
    );

    always @(posedge clk) if (rd_stb) begin
        stb_cnt  <= stb_cnt + 1;
        stb_last <= rd_stb_addr;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] model_vec();
        logic [79:0] v;
        for (int i = 0; i < 10; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic bus_start();
        if (!scl_m) begin
            m_low = 1'b0; wt(8); scl_m = 1'b1; wt(20);
        end
        m_low = 1'b1; wt(20); scl_m = 1'b0; wt(12);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(8); scl_m = 1'b1; wt(20); m_low = 1'b0; wt(20);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wt(8); scl_m = 1'b1; wt(20); scl_m = 1'b0; wt(12);
        end
        m_low = 1'b0; wt(8); scl_m = 1'b1; wt(10);
        ack = ~sda_bus;
        wt(10); scl_m = 1'b0; wt(12);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(8); scl_m = 1'b1; wt(10); b[i] = sda_bus; wt(10); scl_m = 1'b0; wt(12);
        end
        m_low = give_ack; wt(8); scl_m = 1'b1; wt(20); scl_m = 1'b0; wt(12);
        m_low = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte(8'hC0, acks[2]);
        send_byte(a, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] a, input bit split, output logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte(8'hC0, acks[2]);
        send_byte(a, acks[1]);
        if (split) bus_stop();
        bus_start();
        send_byte(8'hC1, acks[0]);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        for (int i = 0; i < 10; i++) if (RW_ADDR[i] == a) model[i] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d;
        logic [7:0] d2;
        logic       k;
        int         s0;
        for (int i = 0; i < 10; i++) model[i] = '0;

        // R8: reset state
        wt(10);
        chk(sda_oe == 1'b0, "R8 sda released in reset", 80'(sda_oe), 80'h0);
        chk(rw_regs == '0, "R8 registers cleared", rw_regs, 80'h0);
        rst = 1'b0;
        wt(10);
        chk(rw_regs[24] == 1'b0, "R8 power bit standby", 80'(rw_regs[24]), 80'h0);

        // Table walk: R2 R4 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] a, w, e;
            {a, w, e} = VEC[v];
            reg_write(a, w, acks);
            model_write(a, w);
            chk(acks == 3'b111, "R2/R5/R6/R7 write acks", 80'(acks), 80'h7);
            chk(rw_regs == model_vec(), "R2/R5/R6/R7 register image", rw_regs, model_vec());
            s0 = stb_cnt;
            reg_read(a, v[0], d, acks);
            chk(acks == 3'b111, "R4 read acks", 80'(acks), 80'h7);
            chk(d == e, "R4/R5/R6/R7 read value", 80'(d), 80'(e));
            chk(stb_cnt == s0 + 1 && stb_last == a, "R9 read strobe",
                80'({stb_cnt - s0, stb_last}), 80'({32'd1, a}));
        end

        // R1: foreign address, then traffic that must be ignored
        bus_start();
        send_byte(8'hC4, k);
        chk(k == 1'b0, "R1 foreign address nack", 80'(k), 80'h0);
        send_byte(8'h0D, k);
        chk(k == 1'b0, "R1 following byte ignored", 80'(k), 80'h0);
        send_byte(8'h99, k);
        bus_stop();
        chk(rw_regs == model_vec(), "R1 registers unchanged", rw_regs, model_vec());

        // R3: multi-byte write keeps only the first byte
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hC0, acks[2]);
        send_byte(8'h0D, acks[1]);
        send_byte(8'h11, acks[0]);
        send_byte(8'h22, k);
        chk(acks == 3'b111 && k, "R3 extra byte acked", 80'({acks, k}), 80'hF);
        send_byte(8'h33, k);
        bus_stop();
        model_write(8'h0D, 8'h11);
        chk(rw_regs == model_vec(), "R3 only first byte stored", rw_regs, model_vec());
        chk(stb_cnt == s0, "R9 no strobe on write", 80'(stb_cnt - s0), 80'h0);

        // R11: write cut by STOP before its data byte
        bus_start();
        send_byte(8'hC0, k);
        send_byte(8'h1E, k);
        bus_stop();
        chk(rw_regs == model_vec(), "R11 aborted write", rw_regs, model_vec());

        // R9: host ACKs the first byte, same register is sent twice
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hC0, k);
        send_byte(8'h1F, k);
        bus_start();
        send_byte(8'hC1, k);
        recv_byte(1'b1, d);
        recv_byte(1'b0, d2);
        bus_stop();
        chk(d == 8'h96 && d2 == 8'h96, "R9 repeated byte", 80'({d, d2}), 80'h9696);
        chk(stb_cnt == s0 + 2 && stb_last == 8'h1F, "R9 two strobes",
            80'({stb_cnt - s0, stb_last}), 80'({32'd2, 8'h1F}));

        // R8: reset in the middle of operation
        rst = 1'b1;
        wt(4);
        rst = 1'b0;
        wt(4);
        chk(rw_regs == '0, "R8 reset clears image", rw_regs, 80'h0);
        for (int i = 0; i < 10; i++) model[i] = '0;
        reg_read(8'h0F, 1'b0, d, acks);
        chk(d == 8'h00, "R8 power register reads standby", 80'(d), 80'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule